// File: doc/BRIEF.md
# Distance-Three Encoded Request/Acknowledge State Machine

This block is a four-state request/acknowledge controller. It holds its state in one 5-bit register, and every legal state code in that register is at least three bit positions away from every other legal code. The decoder maps a stored value that lies within one bit of a legal code to that legal state. The outputs and transitions for that value are the same as for the clean code, and the next update writes the clean code back. A stored value that lies within one bit of no legal code is handled by a default path. That path drives the outputs to their safe values and returns the machine to idle.

In normal use, a client raises `req`. The block shows `busy` until the client reports `done`. It then gives a one-cycle `ack` and waits for `req` to fall before it accepts new work. The `upsetMask` input models a radiation upset. When it is nonzero, its bits are XORed into the stored code at the clock edge instead of the normal update. A unit can use it for in-circuit self-test, and a bench can use it to reach fault states through the ports. `corrErr` reports each absorbed single-bit upset, and `safeRec` reports each forced recovery.

Top module: `safe_fsm_d3`

## Requirements
- R1: After the asynchronous active-low reset `rstN`, the machine is idle, and `busy`, `ack`, `corrErr` and `safeRec` are all low.
- R2: In idle, `req` high moves the machine to the working state at the next edge, and `busy` is high for as long as it stays there. With `req` low, idle is held and `done` has no effect.
- R3: In the working state, `done` high moves the machine to the acknowledge state. `ack` is then high for exactly one cycle, and the machine goes on to the cooldown state regardless of its inputs. With `done` low, the working state is held.
- R4: In cooldown, `busy` and `ack` are low. The machine stays in cooldown while `req` is high and returns to idle at the first edge where `req` is low.
- R5: A nonzero `upsetMask` at an edge replaces the normal update with stored code XOR `upsetMask`. The legal codes are idle=00000, working=00111, acknowledge=11001 and cooldown=11110, with bit 4 as the MSB.
- R6: If the stored code is one bit away from a legal code, `busy`, `ack` and the next transition are exactly those of that legal state. `corrErr` is high for that cycle only, because the clean code is written back at the next edge.
- R7: If the stored code is within one bit of no legal code (for example 01010 or 10100), `safeRec` is high for that cycle and `busy` and `ack` are low. The next state is idle whatever `req` and `done` are.
- R8: `corrErr` and `safeRec` are never high together, and neither of them is ever high during fault-free operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Work request from the client |
| done | input | 1 | Work-complete indication |
| upsetMask | input | 5 | Bits to flip in the stored state code (0 = normal update) |
| busy | output | 1 | High in the working state |
| ack | output | 1 | One-cycle acknowledge |
| corrErr | output | 1 | A single-bit upset was absorbed this cycle |
| safeRec | output | 1 | An uncorrectable code forced recovery this cycle |

## Verification
The hardest situation to reach is a corrupted code that sits in the register for exactly one cycle, in each of the four states and for each of the five bit positions. The acknowledge state is the hardest of these, because it lasts only one cycle. The bench walks the reference model into each state and applies a one-hot `upsetMask` on the next edge. It then drives the inputs that would cause a transition and compares every output with the fault-free expectation, plus the `corrErr` pulse. Two multi-bit masks that land on uncorrectable codes, one from idle and one from the working state, exercise the recovery path while `req` or `done` is held high.

// File: rtl/safe_fsm_pkg.sv
`timescale 1ns/1ps
package safe_fsm_pkg;
  localparam int CODE_W = 5;
  localparam int NUM_ST = 4;
  localparam int IDX_W  = $clog2(NUM_ST);
  localparam int MAX_CORR_DIST = 1;

  typedef logic [CODE_W-1:0] code_t;

  typedef enum logic [IDX_W-1:0] {
    ST_IDLE = 2'd0,
    ST_WORK = 2'd1,
    ST_ACK  = 2'd2,
    ST_COOL = 2'd3
  } st_e;

  localparam code_t CODE_IDLE = 5'b00000;
  localparam code_t CODE_WORK = 5'b00111;
  localparam code_t CODE_ACK  = 5'b11001;
  localparam code_t CODE_COOL = 5'b11110;

  localparam code_t LEGAL_CODES [NUM_ST] = '{CODE_IDLE, CODE_WORK, CODE_ACK, CODE_COOL};

  typedef struct packed {
    logic  recover;
    code_t nextCode;
  } ctrlStrobe_t;
endpackage

// File: rtl/safe_fsm_store.sv
`timescale 1ns/1ps
module safe_fsm_store
  import safe_fsm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  code_t       upsetMask,
  input  ctrlStrobe_t strobe,
  output st_e         stateIdx,
  output logic        corrected,
  output logic        uncorrectable
);
  code_t stored;
  code_t cleanCode;
  logic [NUM_ST-1:0] hit;

  for (genvar gi = 0; gi < NUM_ST; gi++) begin : g_near
    assign hit[gi] = ($countones(stored ^ LEGAL_CODES[gi]) <= MAX_CORR_DIST);
  end

  always_comb begin
    stateIdx = ST_IDLE;
    for (int i = 0; i < NUM_ST; i++) begin
      if (hit[i]) stateIdx = st_e'(IDX_W'(i));
    end
  end

  assign cleanCode     = LEGAL_CODES[stateIdx];
  assign uncorrectable = ~|hit;
  assign corrected     = (|hit) && (stored != cleanCode);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stored <= CODE_IDLE;
    end else if (|upsetMask) begin
      stored <= stored ^ upsetMask;
    end else if (strobe.recover) begin
      stored <= CODE_IDLE;
    end else begin
      stored <= strobe.nextCode;
    end
  end
endmodule

// File: rtl/safe_fsm_ctrl.sv
`timescale 1ns/1ps
module safe_fsm_ctrl
  import safe_fsm_pkg::*;
(
  input  logic        req,
  input  logic        done,
  input  st_e         stateIdx,
  input  logic        uncorrectable,
  output ctrlStrobe_t strobe,
  output logic        busy,
  output logic        ack,
  output logic        safeRec
);
  always_comb begin
    strobe.recover  = 1'b0;
    strobe.nextCode = CODE_IDLE;
    busy    = 1'b0;
    ack     = 1'b0;
    safeRec = 1'b0;
    if (uncorrectable) begin
      strobe.recover = 1'b1;
      safeRec        = 1'b1;
    end else begin
      case (stateIdx)
        ST_IDLE: strobe.nextCode = req ? CODE_WORK : CODE_IDLE;
        ST_WORK: begin
          busy            = 1'b1;
          strobe.nextCode = done ? CODE_ACK : CODE_WORK;
        end
        ST_ACK: begin
          ack             = 1'b1;
          strobe.nextCode = CODE_COOL;
        end
        ST_COOL: strobe.nextCode = req ? CODE_COOL : CODE_IDLE;
        default: strobe.recover = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/safe_fsm_d3.sv
`timescale 1ns/1ps
module safe_fsm_d3
  import safe_fsm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              req,
  input  logic              done,
  input  logic [CODE_W-1:0] upsetMask,
  output logic              busy,
  output logic              ack,
  output logic              corrErr,
  output logic              safeRec
);
  ctrlStrobe_t strobe;
  st_e         stateIdx;
  logic        uncorrectable;

  safe_fsm_store u_store (
    .clk          (clk),
    .rstN         (rstN),
    .upsetMask    (upsetMask),
    .strobe       (strobe),
    .stateIdx     (stateIdx),
    .corrected    (corrErr),
    .uncorrectable(uncorrectable)
  );

  safe_fsm_ctrl u_ctrl (
    .req          (req),
    .done         (done),
    .stateIdx     (stateIdx),
    .uncorrectable(uncorrectable),
    .strobe       (strobe),
    .busy         (busy),
    .ack          (ack),
    .safeRec      (safeRec)
  );
endmodule

// File: rtl/safe_fsm_d3_chk.sv
`timescale 1ns/1ps
module safe_fsm_d3_chk
  import safe_fsm_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              req,
  input logic              done,
  input logic [CODE_W-1:0] upsetMask,
  input logic              busy,
  input logic              ack,
  input logic              corrErr,
  input logic              safeRec
);
  p_exclusive_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(corrErr && safeRec));

  p_safe_outputs_r7: assert property (@(posedge clk) disable iff (!rstN)
    safeRec |-> (!busy && !ack));

  p_recover_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    (safeRec && upsetMask == '0) |=> (!busy && !ack && !safeRec && !corrErr));

  p_corr_one_cycle_r6: assert property (@(posedge clk) disable iff (!rstN)
    (corrErr && upsetMask == '0) |=> !corrErr);

  p_ack_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ack && upsetMask == '0) |=> (!ack && !busy));

  p_busy_exit_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done && upsetMask == '0) |=> busy);

  p_one_role_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && ack));
endmodule

bind safe_fsm_d3 safe_fsm_d3_chk u_chk (.*);

// File: tb/safe_fsm_d3_test.sv
`timescale 1ns/1ps
module safe_fsm_d3_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic req = 1'b0;
  logic done = 1'b0;
  logic [4:0] upsetMask = '0;
  logic busy, ack, corrErr, safeRec;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  // reference model: 0 idle, 1 working, 2 acknowledge, 3 cooldown
  int mState = 0;
  int mPend = 0; // 0 clean, 1 single upset stored, 2 uncorrectable stored

  always #2.5 clk = ~clk;

  safe_fsm_d3 uut (
    .clk(clk), .rstN(rstN), .req(req), .done(done), .upsetMask(upsetMask),
    .busy(busy), .ack(ack), .corrErr(corrErr), .safeRec(safeRec)
  );

  function automatic logic [3:0] expOut();
    logic b, a;
    b = (mPend != 2) && (mState == 1);
    a = (mPend != 2) && (mState == 2);
    return {b, a, mPend == 1, mPend == 2};
  endfunction

  function automatic int nextOf(int s, logic r, logic d);
    case (s)
      0: return r ? 1 : 0;
      1: return d ? 2 : 1;
      2: return 3;
      default: return r ? 3 : 0;
    endcase
  endfunction

  task automatic checkNow(string tag);
    logic [3:0] got;
    got = {busy, ack, corrErr, safeRec};
    checks++;
    if (got !== expOut()) begin
      fails++;
      $display("FAIL %s {busy,ack,corrErr,safeRec} got %b expected %b", tag, got, expOut());
    end
  endtask

  // called at a negedge: check, drive, advance one edge, update model
  task automatic step(string tag, logic r, logic d, logic [4:0] m);
    checkNow(tag);
    req = r; done = d; upsetMask = m;
    @(posedge clk);
    if (m != '0) begin
      mPend = ($countones(m) == 1) ? 1 : 2;
    end else if (mPend == 2) begin
      mState = 0; mPend = 0;
    end else begin
      mState = nextOf(mState, r, d); mPend = 0;
    end
    @(negedge clk);
    upsetMask = '0;
  endtask

  task automatic reach(int t);
    while (mState != t || mPend != 0) begin
      case (mState)
        0: step("R2 R8 walk", 1'b1, 1'b0, '0);
        1: step("R3 R8 walk", 1'b1, 1'b1, '0);
        2: step("R3 R8 walk", 1'b1, 1'b0, '0);
        default: step("R4 R8 walk", 1'b0, 1'b0, '0);
      endcase
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    checkNow("R1 reset state");

    // fault-free sequence
    step("R2 idle hold, done ignored", 1'b0, 1'b1, '0);
    step("R2 idle hold", 1'b0, 1'b0, '0);
    step("R2 req starts", 1'b1, 1'b0, '0);
    step("R2 busy while working", 1'b0, 1'b0, '0);
    step("R3 hold without done", 1'b0, 1'b0, '0);
    step("R3 done", 1'b1, 1'b1, '0);
    step("R3 ack pulse", 1'b1, 1'b0, '0);
    step("R4 cooldown hold", 1'b1, 1'b0, '0);
    step("R4 cooldown hold", 1'b0, 1'b0, '0);
    step("R4 back to idle R8", 1'b0, 1'b0, '0);

    // every single-bit upset in every state
    for (int st = 0; st < 4; st++) begin
      for (int b = 0; b < 5; b++) begin
        reach(st);
        step("R5 R6 before upset", 1'b0, 1'b0, 5'(1 << b));
        case (st)
          0: step("R6 corrected idle", 1'b1, 1'b0, '0);
          1: step("R6 corrected working", 1'b1, 1'b1, '0);
          2: step("R6 corrected ack", 1'b1, 1'b0, '0);
          default: step("R6 corrected cooldown", 1'b0, 1'b0, '0);
        endcase
        step("R6 after write-back", 1'b0, 1'b0, '0);
      end
    end

    // uncorrectable from idle: 00000 ^ 01010
    reach(0);
    step("R5 R7 before upset", 1'b0, 1'b0, 5'b01010);
    step("R7 recovery with req high", 1'b1, 1'b1, '0);
    step("R7 idle after recovery", 1'b0, 1'b0, '0);
    // uncorrectable from working: 00111 ^ 10011 = 10100
    reach(1);
    step("R5 R7 before upset", 1'b0, 1'b0, 5'b10011);
    step("R7 recovery with done high", 1'b1, 1'b1, '0);
    step("R7 idle after recovery R8", 1'b0, 1'b0, '0);
    checkNow("R8 final clean");

    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule